// File: doc/BRIEF.md
# Privilege-Gated Processor Status Word

This block holds a processor's status word: a 4-bit interrupt priority level, a mode bit (0 = supervisor, 1 = user), a stack-select bit, an interrupt-enable bit and four condition flags (carry, zero, sign, overflow). Software-visible updates arrive as a full 32-bit word. The word comes either from an ordinary instruction path or from a return-from-exception path. Privilege rules decide which of the written fields actually take effect.

The interrupt entry sequencer sends two pulses. A normal entry pulse clears the mode, interrupt-enable and stack-select bits in one cycle. A fast entry pulse does the same and also forces the priority level to 15. The packed word is formed combinationally from the stored fields, so the entry logic can capture it for saving in the same cycle it issues the pulse.

Top module: `status_word_reg`

## Requirements
- R1: After reset every field is 0, so `sw_word` reads 0x00000000.
- R2: `sw_word` places carry at bit 0, zero at bit 1, sign at bit 2, overflow at bit 3, interrupt-enable at bit 16, stack-select at bit 17, mode at bit 20 and the priority level at bits 27:24. Every other bit reads 0.
- R3: An accepted write (`wr_en`=1 with no entry pulse) loads the four flags from bits 3:0 of `wr_data` in either mode. The result is visible on `sw_word` after the next rising edge.
- R4: In supervisor mode (mode bit 0), an accepted write loads the priority level, stack-select and interrupt-enable fields from their bit positions in `wr_data`.
- R5: In user mode (mode bit 1), an accepted write leaves the priority level, stack-select, interrupt-enable and mode fields unchanged, whether or not `wr_ret` is set.
- R6: The mode bit loads from bit 20 of `wr_data` only when `wr_ret`=1 and the current mode is supervisor. An ordinary write (`wr_ret`=0) never changes it.
- R7: A normal entry pulse (`ent_clr`) clears mode, interrupt-enable and stack-select in one cycle. It leaves the priority level and the flags unchanged.
- R8: A fast entry pulse (`ent_fast`) clears the same three bits and sets the priority level to 15. The flags are left unchanged.
- R9: When an entry pulse and a write fall in the same cycle, the write is discarded entirely, and the flags keep their old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Full-word write strobe |
| wr_ret | input | 1 | Qualifies the write as coming from a return-from-exception path |
| wr_data | input | 32 | Word to write |
| ent_clr | input | 1 | Normal interrupt or exception entry pulse |
| ent_fast | input | 1 | Fast interrupt entry pulse |
| sw_word | output | 32 | Packed status word, combinational from the stored fields |

## Verification
The two functions that can coincide are a full-word write and an entry pulse. The bench drives both in the same cycle, once with a normal entry and once with a fast entry. Each time, the written word is chosen to differ from the stored flags, level and enable bits. The result is judged by reading `sw_word` after the edge. It must show only the entry's clearing (and, for a fast entry, level 15), with every flag and every other field holding its pre-edge value.

// File: rtl/status_word_reg.sv
module status_word_reg #(
  parameter int LVL_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_ret,
  input  logic [31:0] wr_data,
  input  logic        ent_clr,
  input  logic        ent_fast,
  output logic [31:0] sw_word
);
  localparam int FLG_LO = 0;
  localparam int IE_B   = 16;
  localparam int STK_B  = 17;
  localparam int MODE_B = 20;
  localparam int LVL_LO = 24;
  localparam logic [LVL_W-1:0] LVL_TOP = '1;

  logic [3:0]       flags_q;
  logic [LVL_W-1:0] lvl_q;
  logic             ie_q, stk_q, mode_q;

  wire entry   = ent_clr | ent_fast;
  wire take_wr = wr_en & ~entry;
  wire superv  = ~mode_q;

  logic unused_bits;
  assign unused_bits = ^{wr_data[31:LVL_LO+LVL_W], wr_data[LVL_LO-1:MODE_B+1],
                         wr_data[MODE_B-1:STK_B+1], wr_data[IE_B-1:FLG_LO+4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      lvl_q   <= '0;
      ie_q    <= 1'b0;
      stk_q   <= 1'b0;
      mode_q  <= 1'b0;
    end else if (entry) begin
      ie_q   <= 1'b0;
      stk_q  <= 1'b0;
      mode_q <= 1'b0;
      if (ent_fast) lvl_q <= LVL_TOP;
    end else if (take_wr) begin
      flags_q <= wr_data[FLG_LO +: 4];
      if (superv) begin
        lvl_q <= wr_data[LVL_LO +: LVL_W];
        ie_q  <= wr_data[IE_B];
        stk_q <= wr_data[STK_B];
        if (wr_ret) mode_q <= wr_data[MODE_B];
      end
    end
  end

  always_comb begin
    sw_word = '0;
    sw_word[FLG_LO +: 4]     = flags_q;
    sw_word[IE_B]            = ie_q;
    sw_word[STK_B]           = stk_q;
    sw_word[MODE_B]          = mode_q;
    sw_word[LVL_LO +: LVL_W] = lvl_q;
  end
endmodule

module status_word_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_ret,
  input logic [31:0] wr_data,
  input logic        ent_clr,
  input logic        ent_fast,
  input logic [31:0] sw_word
);
  wire ent = ent_clr | ent_fast;

  // R2
  always_comb begin
    if (rst_n) spare_zero_chk: assert ((sw_word & 32'hF0EC_FFF0) == 32'h0);
  end

  // R3
  flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ent) |=> sw_word[3:0] == $past(wr_data[3:0]));

  // R5
  user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ent && sw_word[20]) |=> $stable(sw_word[27:16]));

  // R6
  mode_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ret && !ent) |=> $stable(sw_word[20]));

  // R7
  entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent |=> (sw_word[20] == 1'b0 && sw_word[17:16] == 2'b00));

  // R8
  fast_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_fast |=> sw_word[27:24] == 4'hF);

  // R9
  entry_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent |=> $stable(sw_word[3:0]));
endmodule

bind status_word_reg status_word_chk i_status_word_chk (.*);

// File: tb/test_status_word_reg.sv
module test_status_word_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_ret = 1'b0, ent_clr = 1'b0, ent_fast = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] sw_word;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  status_word_reg i_status_word_reg (.*);

  // {ent_clr, ent_fast, wr_en, wr_ret}, wr_data, expected sw_word, tag
  localparam int NV = 12;
  localparam logic [67:0] VEC [NV] = '{
    {4'b0010, 32'h0A13_000F, 32'h0A03_000F},  // R4 R3 R6
    {4'b0011, 32'h0511_0005, 32'h0511_0005},  // R6 R4
    {4'b0010, 32'h0F02_0000, 32'h0511_0000},  // R5 R3
    {4'b0011, 32'h0000_0003, 32'h0511_0003},  // R5 R6
    {4'b1000, 32'h0000_0000, 32'h0500_0003},  // R7
    {4'b0011, 32'h0313_0008, 32'h0313_0008},  // R6 R4
    {4'b1010, 32'h0000_0000, 32'h0300_0008},  // R9
    {4'b0100, 32'h0000_0000, 32'h0F00_0008},  // R8
    {4'b0010, 32'hFFFF_FFFF, 32'h0F03_000F},  // R2 R6
    {4'b0011, 32'h00F0_FF0E, 32'h0010_000E},  // R2 R6
    {4'b0110, 32'h0B03_0001, 32'h0F00_000E},  // R8 R9
    {4'b0000, 32'h0B03_0001, 32'h0F00_000E}   // R3
  };
  localparam string TAG [NV] = '{"R4", "R6", "R5", "R5", "R7", "R4",
                                 "R9", "R8", "R2", "R2", "R9", "R3"};

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (sw_word !== exp) begin
      n_bad++;
      $display("FAIL %s: sw_word=%08h expected=%08h", req, sw_word, exp);
    end
  endtask

  initial begin
    #1 check("R1", 32'h0);
    repeat (2) @(negedge clk);
    check("R1", 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ent_clr, ent_fast, wr_en, wr_ret} = VEC[i][67:64];
      wr_data = VEC[i][63:32];
      @(negedge clk);
      {ent_clr, ent_fast, wr_en, wr_ret} = 4'b0000;
      check(TAG[i], VEC[i][31:0]);
    end
    // R1: reset mid-run returns everything to zero
    rst_n = 1'b0;
    #3 check("R1", 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R3: user-mode write still loads flags after reset and return to user
    wr_en = 1'b1; wr_ret = 1'b1; wr_data = 32'h0110_0000;
    @(negedge clk);
    check("R6", 32'h0110_0000);
    wr_ret = 1'b0; wr_data = 32'h0000_000C;
    @(negedge clk);
    wr_en = 1'b0;
    check("R3", 32'h0110_000C);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule